// File: doc/BRIEF.md
# System Control Register Bank

A 4 KB window of 32-bit registers that holds board-level control state. A host reaches it over a plain single-beat bus: an access strobe, a write flag, a byte address, write data and read data. Each access is taken in one clock edge, and its response (read data and an error flag) appears in the cycle after that edge. The bank holds eight general configuration slots, a loop-lock status register with a writable selection mask, and two read-only identification words. Configuration slot 0 bit 0 drives a remap line, and the low bits of slot 1 drive a bank of LED lines.

Which configuration slots exist is fixed at elaboration by the variant code held in bits [11:4] of the identification parameter. An access to a slot that is absent in the build, or to an offset that nothing decodes, reads as zero, changes nothing and raises a one-cycle error pulse. Offsets 0xA0 to 0xAC belong to a neighbouring transaction-channel block. For these offsets the bank raises a select line in the access cycle and returns that block's read word.

A small response state machine sequences the bus response. It has four states: `ST_IDLE` (no access on the last edge), `ST_RD_RSP` (read accepted), `ST_WR_RSP` (write accepted) and `ST_ERR_RSP` (access to an absent or undecoded offset). On each edge it moves from any state to `ST_ERR_RSP` when the access misses. Otherwise it moves to `ST_WR_RSP` for a write, to `ST_RD_RSP` for a read, or to `ST_IDLE` when there is no access.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, slot 0 holds CFG0_RESET and slots 1, 2, 5, 6 and 7 hold zero. With all lock inputs high, the lock register reads 0xFFFF0001. `remap` equals CFG0_RESET bit 0, `led` is zero and `bus_err` is low.
- R2: Slots 0, 1, 2, 5, 6 and 7, when present, take a write in full and return it on a later read. Read data is valid in the cycle after the edge that accepted the read.
- R3: `remap` equals bit 0 of slot 0, and `led[i]` equals bit i of slot 1. Both outputs update in the cycle after the write edge.
- R4: The variant code is ID bits [11:4]. Slots 2 and 5 exist for codes 0x24, 0x47 and 0x36. Slot 6 exists for 0x24 and 0x36. Slot 7 exists only for 0x36. Slot 3 exists only for codes outside {0x24, 0x47, 0x36}.
- R5: Where slot 3 exists, it always reads zero, ignores writes and raises no error.
- R6: Slot 4 (offset 0x10), the auxiliary ID (0xFF8) and the ID (0xFFC) return their parameter values. Writes to them have no effect.
- R7: The lock register at 0x100 is laid out as {mask[31:24], lock inputs[23:16], zeros[15:1], all-locked[0]}. A write changes only the mask, and reset sets the mask to 0xFF.
- R8: The all-locked bit is 1 exactly when every lock input whose mask bit is 1 is high. With a zero mask it reads 1.
- R9: A read of an absent slot or an undecoded offset returns zero. A write there changes nothing. Both raise `bus_err` for exactly the one response cycle, and every decoded access leaves `bus_err` low.
- R10: For offsets 0xA0 to 0xAC, `chan_sel` is high during the access cycle, a read returns `chan_rdata` as sampled at the access edge, and `bus_err` stays low.
- R11: A write to slot 7 changes slot 7 only; slot 6 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after the access |
| bus_err | output | 1 | One-cycle pulse after an access that misses |
| chan_sel | output | 1 | Access targets the transaction-channel window |
| chan_rdata | input | 32 | Read word from the transaction-channel block |
| lock_in | input | 8 | Per-loop locked flags |
| remap | output | 1 | Remap control line |
| led | output | NUM_LED | LED drive lines |

## Verification
The assertions take for granted a host that issues at most one access per cycle, holds `bus_wr` and `bus_addr` steady only within the strobed cycle, and keeps `rst_n` low long enough for one edge. The bench drives every input on the falling edge and leaves one idle cycle between accesses. It draws random addresses from the decoded set and from undecoded gaps. It builds two instances, one with the full slot set and one with slot 3 present, so that each side of the presence rule produces traffic.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int LOCK_W = 8;

    typedef enum logic [3:0] {
        REG_CFG0 = 4'd0,
        REG_CFG1 = 4'd1,
        REG_CFG2 = 4'd2,
        REG_CFG3 = 4'd3,
        REG_CFG4 = 4'd4,
        REG_CFG5 = 4'd5,
        REG_CFG6 = 4'd6,
        REG_CFG7 = 4'd7,
        REG_CHAN = 4'd8,
        REG_LOCK = 4'd9,
        REG_AID  = 4'd10,
        REG_ID   = 4'd11,
        REG_NONE = 4'd15
    } reg_id_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_RSP,
        ST_WR_RSP,
        ST_ERR_RSP
    } rsp_state_t;

    // Variant families that carry the extended slot set
    function automatic logic is_ext(input logic [7:0] code);
        return (code == 8'h24) || (code == 8'h47) || (code == 8'h36);
    endfunction

    function automatic logic slot_present(input logic [7:0] code, input int idx);
        case (idx)
            2, 5:    return is_ext(code);
            3:       return !is_ext(code);
            6:       return (code == 8'h24) || (code == 8'h36);
            7:       return (code == 8'h36);
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic slot_writable(input int idx);
        return (idx != 3) && (idx != 4);
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter logic [7:0]  VCODE  = 8'h36
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_id_t           sel,
    output logic              present
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam int NSLOT  = 8;

    logic [WIDX_W-1:0] widx;
    logic [NSLOT-1:0]  slot_vec;

    assign widx = addr[ADDR_W-1:2];

    for (genvar g = 0; g < NSLOT; g++) begin : g_pres
        assign slot_vec[g] = slot_present(VCODE, g);
    end

    always_comb begin
        sel = REG_NONE;
        if (widx < WIDX_W'(NSLOT))
            sel = reg_id_t'({1'b0, widx[2:0]});
        else if (widx >= WIDX_W'(32'h28) && widx <= WIDX_W'(32'h2B))
            sel = REG_CHAN;
        else if (widx == WIDX_W'(32'h40))
            sel = REG_LOCK;
        else if (widx == WIDX_W'(32'h3FE))
            sel = REG_AID;
        else if (widx == WIDX_W'(32'h3FF))
            sel = REG_ID;
    end

    always_comb begin
        if (sel == REG_NONE)
            present = 1'b0;
        else if (sel[3] == 1'b0)
            present = slot_vec[sel[2:0]];
        else
            present = 1'b1;
    end

endmodule

// File: rtl/sysctl_lockreg.sv
module sysctl_lockreg
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LOCK_W-1:0] mask_wdata,
    input  logic [LOCK_W-1:0] lock_in,
    output logic [31:0]       status
);
    logic [LOCK_W-1:0] mask_q;
    logic              all_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr_en)
            mask_q <= mask_wdata;
    end

    assign all_ok = &(~mask_q | lock_in);
    assign status = {mask_q, lock_in, 15'd0, all_ok};

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));

    // R8
    all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&lock_in) |-> status[0]);

    // R8
    missing_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & ~lock_in) != '0) |-> !status[0]);

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          NUM_LED    = 8,
    parameter logic [31:0] ID_VALUE   = 32'h4104_1360,
    parameter logic [31:0] AID_VALUE  = 32'h0100_0008,
    parameter logic [31:0] CFG4_VALUE = 32'h0000_0002,
    parameter logic [31:0] CFG0_RESET = 32'h0000_0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_err,
    output logic               chan_sel,
    input  logic [31:0]        chan_rdata,
    input  logic [LOCK_W-1:0]  lock_in,
    output logic               remap,
    output logic [NUM_LED-1:0] led
);
    localparam logic [7:0] VCODE = ID_VALUE[11:4];
    localparam int         NSLOT = 8;

    reg_id_t            sel;
    logic               present;
    logic               miss;
    logic               wr_ok;
    logic [NSLOT-1:0][31:0] cfg_v;
    logic [31:0]        lock_status;
    logic [31:0]        rd_val;
    logic [31:0]        rdata_q;
    rsp_state_t         state_q;
    rsp_state_t         state_d;

    sysctl_decode #(.ADDR_W(ADDR_W), .VCODE(VCODE)) u_decode (
        .addr    (bus_addr),
        .sel     (sel),
        .present (present)
    );

    assign miss     = bus_en && !present;
    assign wr_ok    = bus_en && bus_wr && present;
    assign chan_sel = bus_en && (sel == REG_CHAN);

    // Configuration slots: writable ones are flops, the rest constants
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if (slot_writable(g)) begin : g_rw
            logic [31:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= (g == 0) ? CFG0_RESET : 32'd0;
                else if (wr_ok && sel == reg_id_t'(g))
                    q <= bus_wdata;
            end
            assign cfg_v[g] = q;
        end else if (g == 4) begin : g_ro
            assign cfg_v[g] = CFG4_VALUE;
        end else begin : g_zero
            assign cfg_v[g] = 32'd0;
        end
    end

    sysctl_lockreg u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_ok && sel == REG_LOCK),
        .mask_wdata (bus_wdata[31:24]),
        .lock_in    (lock_in),
        .status     (lock_status)
    );

    always_comb begin
        rd_val = 32'd0;
        if (present) begin
            unique case (sel)
                REG_CHAN: rd_val = chan_rdata;
                REG_LOCK: rd_val = lock_status;
                REG_AID:  rd_val = AID_VALUE;
                REG_ID:   rd_val = ID_VALUE;
                default:  rd_val = cfg_v[sel[2:0]];
            endcase
        end
    end

    // Response state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        if (bus_en) begin
            if (miss)
                state_d = ST_ERR_RSP;
            else if (bus_wr)
                state_d = ST_WR_RSP;
            else
                state_d = ST_RD_RSP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= 32'd0;
        else if (bus_en)
            rdata_q <= bus_wr ? 32'd0 : rd_val;
    end

    // Outputs decoded from the response state
    always_comb begin
        bus_err   = 1'b0;
        bus_rdata = 32'd0;
        unique case (state_q)
            ST_IDLE:    bus_rdata = rdata_q;
            ST_RD_RSP:  bus_rdata = rdata_q;
            ST_WR_RSP:  bus_rdata = 32'd0;
            ST_ERR_RSP: bus_err   = 1'b1;
        endcase
    end

    assign remap = cfg_v[0][0];
    assign led   = cfg_v[1][NUM_LED-1:0];

    // R3
    remap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr[ADDR_W-1:2] == '0) |=> (remap == $past(bus_wdata[0])));

    // R9
    err_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_en));

    // R9
    err_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 32'd0));

    // R10
    chan_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_sel |=> !bus_err);

    // R11
    slot6_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr[ADDR_W-1:2] == 7) |=> $stable(cfg_v[6]));

endmodule

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] chan_rdata = '0;
    logic [7:0]  lock_in = 8'hFF;

    logic [31:0] m_rdata, a_rdata;
    logic        m_err, a_err, m_chan, a_chan, m_remap, a_remap;
    logic [7:0]  m_led, a_led;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] rd_m, rd_a;
    logic        er_m, er_a;

    always #10 clk = ~clk;

    sysctl_regbank #(.ID_VALUE(32'h4104_1360), .CFG0_RESET(32'h1)) u_sysctl_regbank (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(m_rdata), .bus_err(m_err), .chan_sel(m_chan),
        .chan_rdata(chan_rdata), .lock_in(lock_in), .remap(m_remap), .led(m_led));

    sysctl_regbank #(.ID_VALUE(32'h4104_1110), .CFG0_RESET(32'h0)) u_sysctl_regbank_alt (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(a_rdata), .bus_err(a_err), .chan_sel(a_chan),
        .chan_rdata(chan_rdata), .lock_in(lock_in), .remap(a_remap), .led(a_led));

    function automatic logic [31:0] exp_lock(input logic [7:0] mask, input logic [7:0] fl);
        return {mask, fl, 15'd0, &(~mask | fl)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        rd_m = m_rdata; rd_a = a_rdata; er_m = m_err; er_a = a_err;
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] mask_now;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 remap", {31'd0, m_remap}, 32'd1);
        chk("R1 alt remap", {31'd0, a_remap}, 32'd0);
        chk("R1 led", {24'd0, m_led}, 32'd0);
        access(0, 12'h000, 0); chk("R1 cfg0", rd_m, 32'h1);
        access(0, 12'h004, 0); chk("R1 cfg1", rd_m, 32'h0);
        access(0, 12'h01C, 0); chk("R1 cfg7", rd_m, 32'h0);
        access(0, 12'h100, 0); chk("R1 lock", rd_m, 32'hFFFF_0001);
        chk("R1 err", {31'd0, er_m}, 32'd0);

        // R2 / R4 writable slots on the full variant
        access(1, 12'h008, 32'hA5A5_1234); access(0, 12'h008, 0); chk("R2 cfg2", rd_m, 32'hA5A5_1234);
        access(1, 12'h014, 32'h0BAD_CAFE); access(0, 12'h014, 0); chk("R2 cfg5", rd_m, 32'h0BAD_CAFE);
        access(1, 12'h018, 32'h1357_9BDF); access(0, 12'h018, 0); chk("R2 cfg6", rd_m, 32'h1357_9BDF);
        // R11 slot 7 write leaves slot 6
        access(1, 12'h01C, 32'hFEED_0007); access(0, 12'h01C, 0); chk("R11 cfg7", rd_m, 32'hFEED_0007);
        access(0, 12'h018, 0); chk("R11 cfg6 kept", rd_m, 32'h1357_9BDF);

        // R4 absence on alt variant (code 0x11): slots 2,5,6,7 absent
        access(0, 12'h008, 0); chk("R4 alt cfg2 zero", rd_a, 0); chk("R4 alt cfg2 err", {31'd0, er_a}, 1);
        access(0, 12'h01C, 0); chk("R4 alt cfg7 err", {31'd0, er_a}, 1);
        // R4 slot 3 absent on the full variant
        access(0, 12'h00C, 0); chk("R4 cfg3 err", {31'd0, er_m}, 1); chk("R4 cfg3 zero", rd_m, 0);
        // R5 slot 3 present on alt
        access(1, 12'h00C, 32'hFFFF_FFFF);
        chk("R5 alt write err", {31'd0, er_a}, 0);
        access(0, 12'h00C, 0); chk("R5 alt cfg3", rd_a, 0); chk("R5 alt no err", {31'd0, er_a}, 0);

        // R6 read-only identification
        access(1, 12'h010, 32'hDEAD_BEEF); access(0, 12'h010, 0); chk("R6 cfg4", rd_m, 32'h2);
        access(1, 12'hFF8, 32'hDEAD_BEEF); access(0, 12'hFF8, 0); chk("R6 aid", rd_m, 32'h0100_0008);
        access(1, 12'hFFC, 32'hDEAD_BEEF); access(0, 12'hFFC, 0); chk("R6 id", rd_m, 32'h4104_1360);
        chk("R6 alt id", rd_a, 32'h4104_1110);

        // R7 only mask bits move
        lock_in = 8'h3C;
        access(1, 12'h100, 32'h1234_5678); access(0, 12'h100, 0);
        chk("R7 lock write", rd_m, exp_lock(8'h12, 8'h3C));
        // R8 all-locked combination
        access(1, 12'h100, 32'h0F00_0000);
        lock_in = 8'hF0; access(0, 12'h100, 0); chk("R8 missing", rd_m, exp_lock(8'h0F, 8'hF0));
        lock_in = 8'h0F; access(0, 12'h100, 0); chk("R8 all set", rd_m, exp_lock(8'h0F, 8'h0F));
        access(1, 12'h100, 32'h0000_0000);
        lock_in = 8'h00; access(0, 12'h100, 0); chk("R8 zero mask", rd_m, 32'h0000_0001);

        // R9 undecoded offsets
        access(0, 12'h200, 0); chk("R9 read zero", rd_m, 0); chk("R9 read err", {31'd0, er_m}, 1);
        access(1, 12'h204, 32'h1); chk("R9 write err", {31'd0, er_m}, 1);
        @(negedge clk); chk("R9 pulse ends", {31'd0, m_err}, 0);

        // R10 channel window
        chan_rdata = 32'hCAFE_F00D;
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 12'h0A8;
        #1 chk("R10 chan_sel", {31'd0, m_chan}, 1);
        @(negedge clk);
        rd_m = m_rdata; er_m = m_err; bus_en = 1'b0;
        chk("R10 chan data", rd_m, 32'hCAFE_F00D); chk("R10 no err", {31'd0, er_m}, 0);

        // R3 outputs
        access(1, 12'h000, 32'h0); chk("R3 remap low", {31'd0, m_remap}, 0);
        access(1, 12'h000, 32'h3); chk("R3 remap high", {31'd0, m_remap}, 1);

        // Random mix: LEDs, lock mask, undecoded gaps
        mask_now = 8'h00;
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            logic [1:0] kind;
            r = $urandom;
            kind = 2'($urandom % 3);
            if (kind == 0) begin
                access(1, 12'h004, r);
                chk("R3 led", {24'd0, m_led}, {24'd0, r[7:0]});
                access(0, 12'h004, 0); chk("R2 cfg1", rd_m, r);
            end else if (kind == 1) begin
                mask_now = r[31:24];
                access(1, 12'h100, r);
                lock_in = 8'($urandom);
                access(0, 12'h100, 0); chk("R8 lock random", rd_m, exp_lock(mask_now, lock_in));
            end else begin
                access(0, {4'h5, r[7:2], 2'b00}, 0);
                chk("R9 random gap", {31'd0, er_m}, 1);
                chk("R9 random zero", rd_m, 0);
            end
        end

        finish_run();
    end
endmodule